// File: doc/BRIEF.md
# Timer Output Compare Pin Controller

This block turns compare events from a shared 16-bit timer count into values on an 8-bit timer port. Each of the eight channels holds a 16-bit compare value and a 2-bit pin action. When the count is presented with its increment strobe and equals a channel's compare value, that channel's action is applied to its own pin at the next clock edge. The action only applies if the channel is selected for output compare.

Channel 7 is also the master channel. A mask register names a set of pins that channel 7 owns. Pins in the mask ignore their own channel's action. When channel 7 matches, all masked pins load the matching bits of a channel-7 data register in the same edge.

Pin direction is resolved per pin from three sources: the data-direction register, the output-compare select register and the mask. Forcing a pin to drive never alters the stored direction register. Software reaches every register through a simple single-cycle read/write bus.

Top module: `tmr_oc_pin_ctrl`

## Requirements
- R1: After reset, every register reads 0 and both `pin_o` and `pin_oe_o` are 0.
- R2: The register bus has the following address map:
  - addresses 0..7: compare value of channel 0..7 (16 bits);
  - address 8: the action word, with channel n in bits [2n+1:2n];
  - address 9: the output-compare select register;
  - address 10: the data-direction register;
  - address 11: the mask register;
  - address 12: the channel-7 data register.

  A write takes effect at the clock edge. Reads are combinational, with unused bits read as 0. Addresses 13..15 read as 0 and ignore writes.
- R3: The action encoding is 00 none, 01 toggle, 10 clear, 11 set. A channel matches when `cnt_inc_i`=1 and `cnt_i` equals its compare value. If a channel matches, its select bit is 1 and its mask bit is 0, its pin takes the action's result at that clock edge.
- R4: A pin does not change in any of these cases: `cnt_inc_i` is 0, the count differs from the compare value, or the channel's select bit is 0.
- R5: While mask bit n is 1, channel n's action has no effect on pin n.
- R6: On a channel-7 match, every pin with its mask bit at 1 takes the same-index bit of the channel-7 data register. This happens whatever the select bit of channel 7. Pins with mask bit 0 are not touched by the channel-7 data.
- R7: When channel n and channel 7 match in the same cycle and mask bit n is 1, pin n takes the channel-7 data bit. Unmasked pins apply their own action in that same cycle.
- R8: `pin_oe_o[n]` is 1 when select bit n is 1 and either mask bit n is 1 or action n is not 00. Otherwise it equals data-direction bit n.
- R9: The data-direction register changes only by a bus write to address 10. A forced output leaves its read-back value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| cnt_i | input | 16 | Timer count value |
| cnt_inc_i | input | 1 | Count valid/increment strobe; compares only when 1 |
| pin_o | output | 8 | Port pin values |
| pin_oe_o | output | 8 | Per-pin output enable |

## Verification
A wrong pin latch or action decode shows on `pin_o` one clock after the matching count is presented. This is why the bench samples one cycle after each strobe, starting from every prior pin value and every action on every channel. A broken mask priority or merge of simultaneous matches shows as a pin that follows its action instead of the channel-7 data bit on that same edge. Direction faults are combinational and appear on `pin_oe_o` as soon as the relevant register write lands. Any write-through of a forced output into the direction register shows on the next bus read of address 10.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int DW  = 16;
  localparam int AW  = 4;
  localparam int MCH = NCH - 1;

  localparam int ADDR_ACT = NCH;
  localparam int ADDR_IOS = NCH + 1;
  localparam int ADDR_DDR = NCH + 2;
  localparam int ADDR_MSK = NCH + 3;
  localparam int ADDR_DAT = NCH + 4;

  localparam logic [1:0] ACT_OFF = 2'b00;
  localparam logic [1:0] ACT_TGL = 2'b01;
  localparam logic [1:0] ACT_CLR = 2'b10;
  localparam logic [1:0] ACT_SET = 2'b11;
endpackage

// File: rtl/tmr_oc_regs.sv
module tmr_oc_regs
  import tmr_oc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [NCH-1:0][CW-1:0]   cmp_o,
  output logic [NCH-1:0][1:0]      act_o,
  output logic [NCH-1:0]           ios_o,
  output logic [NCH-1:0]           ddr_o,
  output logic [NCH-1:0]           msk_o,
  output logic [NCH-1:0]           dat_o
);
  logic [NCH-1:0][CW-1:0] cmp_q;
  logic [2*NCH-1:0]       act_q;
  logic [NCH-1:0]         ios_q, ddr_q, msk_q, dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      act_q <= '0;
      ios_q <= '0;
      ddr_q <= '0;
      msk_q <= '0;
      dat_q <= '0;
    end else if (we_i) begin
      for (int n = 0; n < NCH; n++) begin
        if (addr_i == AW'(n)) cmp_q[n] <= wdata_i[CW-1:0];
      end
      if (addr_i == AW'(ADDR_ACT)) act_q <= wdata_i[2*NCH-1:0];
      if (addr_i == AW'(ADDR_IOS)) ios_q <= wdata_i[NCH-1:0];
      if (addr_i == AW'(ADDR_DDR)) ddr_q <= wdata_i[NCH-1:0];
      if (addr_i == AW'(ADDR_MSK)) msk_q <= wdata_i[NCH-1:0];
      if (addr_i == AW'(ADDR_DAT)) dat_q <= wdata_i[NCH-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == AW'(n)) rdata_o = DW'(cmp_q[n]);
    end
    if (addr_i == AW'(ADDR_ACT)) rdata_o = DW'(act_q);
    if (addr_i == AW'(ADDR_IOS)) rdata_o = DW'(ios_q);
    if (addr_i == AW'(ADDR_DDR)) rdata_o = DW'(ddr_q);
    if (addr_i == AW'(ADDR_MSK)) rdata_o = DW'(msk_q);
    if (addr_i == AW'(ADDR_DAT)) rdata_o = DW'(dat_q);
  end

  assign cmp_o = cmp_q;
  assign act_o = act_q;
  assign ios_o = ios_q;
  assign ddr_o = ddr_q;
  assign msk_o = msk_q;
  assign dat_o = dat_q;
endmodule

// File: rtl/tmr_oc_cmp.sv
module tmr_oc_cmp
  import tmr_oc_pkg::*;
(
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_inc_i,
  input  logic [CW-1:0] cmp_i,
  output logic          match_o
);
  assign match_o = cnt_inc_i && (cnt_i == cmp_i);
endmodule

// File: rtl/tmr_oc_pin.sv
module tmr_oc_pin
  import tmr_oc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_i,
  input  logic       force_i,
  input  logic       msk_i,
  input  logic       ios_i,
  input  logic       ddr_i,
  input  logic [1:0] act_i,
  input  logic       fdat_i,
  output logic       pin_o,
  output logic       oe_o
);
  logic pin_q, pin_d;

  // mask owns the pin: own action is locked out, only master data lands
  always_comb begin
    pin_d = pin_q;
    if (msk_i) begin
      if (force_i) pin_d = fdat_i;
    end else if (ios_i && match_i) begin
      case (act_i)
        ACT_TGL: pin_d = ~pin_q;
        ACT_CLR: pin_d = 1'b0;
        ACT_SET: pin_d = 1'b1;
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;
  assign oe_o  = (ios_i && (msk_i || (act_i != ACT_OFF))) ? 1'b1 : ddr_i;
endmodule

// File: rtl/tmr_oc_pin_ctrl.sv
module tmr_oc_pin_ctrl
  import tmr_oc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_inc_i,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] pin_oe_o
);
  logic [NCH-1:0][CW-1:0] cmp_q;
  logic [NCH-1:0][1:0]    act_q;
  logic [NCH-1:0]         ios_q, ddr_q, msk_q, dat_q;
  logic [NCH-1:0]         match;

  tmr_oc_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .cmp_o   (cmp_q),
    .act_o   (act_q),
    .ios_o   (ios_q),
    .ddr_o   (ddr_q),
    .msk_o   (msk_q),
    .dat_o   (dat_q)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    tmr_oc_cmp u_cmp (
      .cnt_i     (cnt_i),
      .cnt_inc_i (cnt_inc_i),
      .cmp_i     (cmp_q[n]),
      .match_o   (match[n])
    );

    tmr_oc_pin u_pin (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .match_i (match[n]),
      .force_i (match[MCH]),
      .msk_i   (msk_q[n]),
      .ios_i   (ios_q[n]),
      .ddr_i   (ddr_q[n]),
      .act_i   (act_q[n]),
      .fdat_i  (dat_q[n]),
      .pin_o   (pin_o[n]),
      .oe_o    (pin_oe_o[n])
    );
  end
endmodule

// File: rtl/tmr_oc_pin_ctrl_chk.sv
module tmr_oc_pin_ctrl_chk
  import tmr_oc_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bus_we_i,
  input logic [AW-1:0]  bus_addr_i,
  input logic [CW-1:0]  cnt_i,
  input logic           cnt_inc_i,
  input logic [NCH-1:0] pin_o,
  input logic [NCH-1:0] pin_oe_o,
  input logic [CW-1:0]  cmp_m,
  input logic [NCH-1:0] msk,
  input logic [NCH-1:0] ios,
  input logic [NCH-1:0] ddr,
  input logic [NCH-1:0] dat
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_inc_i |=> $stable(pin_o)); // R4

  AST_MASTER_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_inc_i && cnt_i == cmp_m) |=> ((pin_o & $past(msk)) == ($past(dat) & $past(msk)))); // R6

  AST_MASK_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cnt_inc_i && cnt_i == cmp_m) |=> ((pin_o & $past(msk)) == ($past(pin_o) & $past(msk)))); // R5

  AST_OE_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((msk & ios & ~pin_oe_o) == '0)); // R8

  AST_OE_FOLLOW_DDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~ios & (pin_oe_o ^ ddr)) == '0)); // R8

  AST_DDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == AW'(ADDR_DDR)) |=> $stable(ddr)); // R9
endmodule

bind tmr_oc_pin_ctrl tmr_oc_pin_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .cnt_i      (cnt_i),
  .cnt_inc_i  (cnt_inc_i),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .cmp_m      (cmp_q[tmr_oc_pkg::MCH]),
  .msk        (msk_q),
  .ios        (ios_q),
  .ddr        (ddr_q),
  .dat        (dat_q)
);

// File: tb/tmr_oc_pin_ctrl_test.sv
module tmr_oc_pin_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [15:0] cnt_i = '0;
  logic        cnt_inc_i = 1'b0;
  logic [7:0]  pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] CMP7 = 16'h0807;

  always #2 clk = ~clk;

  tmr_oc_pin_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .cnt_i(cnt_i),
    .cnt_inc_i(cnt_inc_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  function automatic logic [15:0] cmp_of(int n);
    return (n == 7) ? CMP7 : 16'(16'h0100 * (n + 1) + n);
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk); #1;
    bus_we_i = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [15:0] exp);
    @(negedge clk);
    bus_addr_i = a;
    #1 chk(req, bus_rdata_o, exp);
  endtask

  task automatic step(logic [15:0] c, logic inc);
    @(negedge clk);
    cnt_i = c; cnt_inc_i = inc;
    @(posedge clk); #1;
    cnt_inc_i = 1'b0;
  endtask

  // put pin n to v through a master-channel force, then release the mask
  task automatic set_pin(int n, logic v);
    wr(4'd11, 16'(1 << n));
    wr(4'd12, 16'(v) << n);
    step(CMP7, 1'b1);
    wr(4'd11, 16'h0000);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] prev, exp8, m, d;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk("R1 pin_o", 16'(pin_o), 16'h0);
    chk("R1 pin_oe_o", 16'(pin_oe_o), 16'h0);
    for (int a = 0; a < 16; a++) rd("R1 reg reset", 4'(a), 16'h0);

    // R2 register map read-back, unused addresses ignore writes
    for (int a = 0; a < 16; a++) wr(4'(a), 16'hA5C3 ^ 16'(a * 16'h1111));
    for (int a = 0; a < 16; a++) begin
      logic [15:0] w;
      w = 16'hA5C3 ^ 16'(a * 16'h1111);
      if (a < 9) rd("R2 wide reg", 4'(a), w);
      else if (a < 13) rd("R2 byte reg", 4'(a), {8'h00, w[7:0]});
      else rd("R2 unused addr", 4'(a), 16'h0);
    end
    for (int a = 8; a < 13; a++) wr(4'(a), 16'h0000);
    for (int n = 0; n < 8; n++) wr(4'(n), cmp_of(n));

    // R3 / R4 every channel, every action, both prior pin values
    for (int n = 0; n < 8; n++) begin
      for (int a = 0; a < 4; a++) begin
        for (int v = 0; v < 2; v++) begin
          logic ev;
          set_pin(n, 1'(v));
          wr(4'd8, 16'(a) << (2 * n));
          wr(4'd9, 16'(1 << n));
          step(cmp_of(n), 1'b0);
          chk("R4 no strobe", 16'(pin_o[n]), 16'(v));
          step(cmp_of(n) + 16'd1, 1'b1);
          chk("R4 count differs", 16'(pin_o[n]), 16'(v));
          ev = (a == 1) ? ~1'(v) : (a == 2) ? 1'b0 : (a == 3) ? 1'b1 : 1'(v);
          step(cmp_of(n), 1'b1);
          chk("R3 action applied", 16'(pin_o[n]), 16'(ev));
          wr(4'd9, 16'h0000);
          step(cmp_of(n), 1'b1);
          chk("R4 select clear", 16'(pin_o[n]), 16'(ev));
        end
      end
    end

    // R5 mask locks out own action
    for (int n = 0; n < 7; n++) begin
      for (int a = 1; a < 4; a++) begin
        for (int v = 0; v < 2; v++) begin
          set_pin(n, 1'(v));
          wr(4'd8, 16'(a) << (2 * n));
          wr(4'd9, 16'(1 << n));
          wr(4'd11, 16'(1 << n));
          step(cmp_of(n), 1'b1);
          chk("R5 masked pin holds", 16'(pin_o[n]), 16'(v));
          wr(4'd11, 16'h0000);
          wr(4'd9, 16'h0000);
        end
      end
    end

    // R6 master data onto masked pins only
    wr(4'd8, 16'h0000);
    wr(4'd9, 16'h0000);
    wr(4'd11, 16'hFF);
    wr(4'd12, 16'h00);
    step(CMP7, 1'b1);
    chk("R6 force all zero", 16'(pin_o), 16'h00);
    for (int k = 0; k < 16; k++) begin
      m = 8'(k * 37 + 5);
      d = 8'(k * 91 + 3);
      prev = pin_o;
      wr(4'd11, 16'(m));
      wr(4'd12, 16'(d));
      step(CMP7, 1'b1);
      exp8 = (d & m) | (prev & ~m);
      chk("R6 masked load", 16'(pin_o), 16'(exp8));
    end

    // R7 simultaneous matches on all channels
    for (int n = 0; n < 8; n++) wr(4'(n), 16'h4444);
    wr(4'd11, 16'hFF);
    wr(4'd12, 16'h00);
    step(16'h4444, 1'b1);
    wr(4'd8, 16'hFFFF);
    wr(4'd9, 16'hFF);
    wr(4'd11, 16'h0F);
    step(16'h4444, 1'b1);
    chk("R7 data beats set", 16'(pin_o), 16'hF0);
    wr(4'd8, 16'h5555);
    wr(4'd11, 16'h3C);
    wr(4'd12, 16'hA5);
    prev = pin_o;
    step(16'h4444, 1'b1);
    exp8 = (8'hA5 & 8'h3C) | (~prev & ~8'h3C);
    chk("R7 data beats toggle", 16'(pin_o), 16'(exp8));

    // R8 direction resolution sweep, R9 ddr untouched
    for (int c = 0; c < 32; c++) begin
      logic i_b, m_b, d_b;
      logic [1:0] a_b;
      i_b = c[0]; m_b = c[1]; d_b = c[2]; a_b = 2'(c >> 3);
      wr(4'd9, 16'(i_b) << 3);
      wr(4'd11, 16'(m_b) << 3);
      wr(4'd10, 16'(d_b) << 3);
      wr(4'd8, 16'(a_b) << 6);
      @(negedge clk);
      chk("R8 oe pin3", 16'(pin_oe_o[3]),
          16'((i_b && (m_b || a_b != 2'b00)) ? 1'b1 : d_b));
      step(16'h4444, 1'b1);
      rd("R9 ddr unchanged", 4'd10, 16'(d_b) << 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule